// File: doc/BRIEF.md
# Touch Panel Drive and Pen-Detect Controller

This block decides, once per system clock, which resistive-panel plates are driven, which plate or auxiliary input feeds the converter, and whether the pen-detect path is connected. The path grounds the lower Y plate and weakly pulls up the upper X plate. Its inputs are the serial interface state: active-low select, the serial clock level, the 3-bit channel address, the two power-down bits, the single-ended/differential mode bit, and a conversion-window flag from the sequencer. The window runs from the 5th to the 20th falling serial-clock edge. A raw contact flag from the panel comparator is also an input.

The drive and pen-path conditions are computed combinationally and then registered. A break-before-make sequencer sits between the conditions and the output registers. When the outputs must change from one active configuration to a different one, all plate drivers and the pen path are first held off for `DEAD_CYCLES` clocks. Examples are the pen path giving way to a drive pattern, or one drive pattern giving way to another. Two opposing connections on the same plate therefore never overlap. The active-low pen interrupt is registered on the same edge as the pen-path enable.

Top module: `panel_ctrl`

## Requirements
- R1: While rst_ni is low, plate_sw_o is 0, drv_en_o is 0, pen_det_en_o is 1, pen_irq_no is 1 and adc_src_o is 0 (none).
- R2: plate_sw_o bit 3 drives upper X, bit 2 drives upper Y, bit 1 drives lower X and bit 0 drives lower Y. Address 101 (X) selects 1010, address 001 (Y) selects 0101, and addresses 011 (Z1) and 100 (Z2) select 0110.
- R3: The drive request is true when cs_ni is low, the address is one of 001, 011, 100 or 101, and either pd_i[0] is 1 or conv_i is 1. Otherwise plate_sw_o goes to 0 and drv_en_o goes to 0.
- R4: The pen-path request is true in two cases. The first is cs_ni low with conv_i 0 and pd_i[0] 0. The second is cs_ni high with sclk_i 0 and pd_i not equal to 11.
- R5: With pd_i = 11 and the block deselected, the pen path is off and pen_irq_no stays 1 even while touch_i is 1.
- R6: pen_irq_no is 0 exactly when the pen path is enabled on that edge and touch_i was 1. It changes on the same edge as pen_det_en_o.
- R7: When the outputs must change between two different active configurations, the plate drivers and the pen path are all off for DEAD_CYCLES clocks (default 1) first. A change between equal drive patterns, or from or to all-off, takes effect directly. A plate drive and the pen path are never on together.
- R8: With single_ended_i = 1, adc_src_o encodes the converter input: 000→7 (TEMP0), 010→4 (battery), 110→5 (IN1), 111→8 (TEMP1), 001 and 011→1 (upper X), 100→3 (lower Y), 101→2 (upper Y).
- R9: With single_ended_i = 0, address 110 gives 6 (IN2), addresses 000, 010 and 111 give 0 (none), and the panel addresses map as in R8.
- R10: Every output is registered. An input change is visible after exactly one rising clock edge (plus the R7 gap), and adc_src_o is 0 while cs_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock level, synchronous to clk_i |
| addr_i | input | 3 | Channel address |
| pd_i | input | 2 | Power-down bits, [1] reference, [0] converter/drivers |
| single_ended_i | input | 1 | 1 = single-ended, 0 = differential |
| conv_i | input | 1 | Conversion window flag |
| touch_i | input | 1 | Raw panel contact flag |
| drv_en_o | output | 1 | Any plate driver on |
| pen_det_en_o | output | 1 | Pen-detect pull-up and ground path on |
| plate_sw_o | output | 4 | Per-plate drive switches (upper X, upper Y, lower X, lower Y) |
| adc_src_o | output | 4 | Converter input selection code |
| pen_irq_no | output | 1 | Pen interrupt, active low |

## Verification
One input change can ask in the same cycle for the pen path to drop and for a drive pattern to start. A second case is a falling chip select with an X address and pd_i[0] set, a third is the conversion window opening with pd_i[0] clear. The bench provokes these cases and also consecutive address changes between different axes. It expects one all-off cycle before the new drive pattern, and no gap between Z1 and Z2, which share a pattern. The interrupt is judged on the same edge: with touch_i held, pen_irq_no must stay high through the drive phase and fall on the edge where the pen path returns.

// File: rtl/panel_ctrl_pkg.sv
package panel_ctrl_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PD_W   = 2;
  localparam int unsigned PLATES = 4;
  localparam int unsigned SRC_W  = 4;

  localparam int unsigned P_YN = 0;
  localparam int unsigned P_XN = 1;
  localparam int unsigned P_YP = 2;
  localparam int unsigned P_XP = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 4'd0,
    SRC_XP    = 4'd1,
    SRC_YP    = 4'd2,
    SRC_YN    = 4'd3,
    SRC_VBAT  = 4'd4,
    SRC_IN1   = 4'd5,
    SRC_IN2   = 4'd6,
    SRC_TEMP0 = 4'd7,
    SRC_TEMP1 = 4'd8
  } adc_src_e;

  typedef logic [PLATES-1:0] plate_vec_t;
endpackage

// File: rtl/panel_route_dec.sv
module panel_route_dec
  import panel_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              single_ended_i,
  output logic              axis_o,
  output plate_vec_t        pat_o,
  output adc_src_e          src_o
);
  always_comb begin
    axis_o = 1'b0;
    pat_o  = '0;
    src_o  = SRC_NONE;
    case (addr_i)
      3'b000: src_o = single_ended_i ? SRC_TEMP0 : SRC_NONE;
      3'b001: begin  // Y axis
        axis_o     = 1'b1;
        pat_o[P_YP] = 1'b1;
        pat_o[P_YN] = 1'b1;
        src_o      = SRC_XP;
      end
      3'b010: src_o = single_ended_i ? SRC_VBAT : SRC_NONE;
      3'b011: begin  // Z1
        axis_o     = 1'b1;
        pat_o[P_YP] = 1'b1;
        pat_o[P_XN] = 1'b1;
        src_o      = SRC_XP;
      end
      3'b100: begin  // Z2
        axis_o     = 1'b1;
        pat_o[P_YP] = 1'b1;
        pat_o[P_XN] = 1'b1;
        src_o      = SRC_YN;
      end
      3'b101: begin  // X axis
        axis_o     = 1'b1;
        pat_o[P_XP] = 1'b1;
        pat_o[P_XN] = 1'b1;
        src_o      = SRC_YP;
      end
      3'b110: src_o = single_ended_i ? SRC_IN1 : SRC_IN2;
      default: src_o = single_ended_i ? SRC_TEMP1 : SRC_NONE;
    endcase
  end
endmodule

// File: rtl/panel_en_logic.sv
module panel_en_logic
  import panel_ctrl_pkg::*;
(
  input  logic            cs_ni,
  input  logic            sclk_i,
  input  logic            axis_i,
  input  logic [PD_W-1:0] pd_i,
  input  logic            conv_i,
  output logic            drv_req_o,
  output logic            pen_req_o
);
  logic sel;
  assign sel = ~cs_ni;

  // drivers: held by pd0 outside the window, always inside it
  assign drv_req_o = (sel & ~conv_i & axis_i & pd_i[0])
                   | (sel & axis_i & conv_i);

  // pen path: idle between conversions, or deselected with clock low
  assign pen_req_o = (sel & ~conv_i & ~pd_i[0])
                   | (cs_ni & ~sclk_i & ~(pd_i[1] & pd_i[0]));
endmodule

// File: rtl/panel_sw_seq.sv
module panel_sw_seq
  import panel_ctrl_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drv_req_i,
  input  logic       pen_req_i,
  input  plate_vec_t pat_i,
  input  logic       touch_i,
  output plate_vec_t plate_sw_o,
  output logic       pen_det_o,
  output logic       pen_irq_no
);
  localparam int unsigned GAP_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

  plate_vec_t want_sw, sw_q, sw_d;
  logic pen_q, pen_d, irq_nq;
  logic cur_act, want_act, change, conflict, hold;

  assign want_sw  = drv_req_i ? pat_i : '0;
  assign cur_act  = (|sw_q) | pen_q;
  assign want_act = (|want_sw) | pen_req_i;
  assign change   = (want_sw != sw_q) || (pen_req_i != pen_q);
  assign conflict = cur_act & want_act & change;

  generate
    if (DEAD_CYCLES > 0) begin : g_gap
      logic [GAP_W-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            gap_q <= '0;
        else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
        else if (conflict)      gap_q <= GAP_W'(DEAD_CYCLES - 1);
      end
      assign hold = (gap_q != '0) | conflict;

      a_r7_no_direct_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|sw_q) && (|$past(sw_q))) |-> (sw_q == $past(sw_q)));
      a_r7_pen_then_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pen_q |=> (sw_q == '0));
      a_r7_drive_then_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|sw_q) |=> !pen_q);
    end else begin : g_nogap
      assign hold = 1'b0;
    end
  endgenerate

  assign sw_d  = hold ? '0 : want_sw;
  assign pen_d = hold ? 1'b0 : pen_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '0;
      pen_q  <= 1'b1;
      irq_nq <= 1'b1;
    end else begin
      sw_q   <= sw_d;
      pen_q  <= pen_d;
      irq_nq <= ~(pen_d & touch_i);
    end
  end

  assign plate_sw_o = sw_q;
  assign pen_det_o  = pen_q;
  assign pen_irq_no = irq_nq;

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|sw_q) && pen_q));
  a_r6_irq_needs_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_nq |-> pen_q);
endmodule

// File: rtl/panel_ctrl.sv
module panel_ctrl
  import panel_ctrl_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PD_W-1:0]   pd_i,
  input  logic              single_ended_i,
  input  logic              conv_i,
  input  logic              touch_i,
  output logic              drv_en_o,
  output logic              pen_det_en_o,
  output logic [PLATES-1:0] plate_sw_o,
  output logic [SRC_W-1:0]  adc_src_o,
  output logic              pen_irq_no
);
  logic       axis, drv_req, pen_req;
  plate_vec_t pat, sw;
  adc_src_e   dec_src, src_q;

  panel_route_dec u_dec (
    .addr_i         (addr_i),
    .single_ended_i (single_ended_i),
    .axis_o         (axis),
    .pat_o          (pat),
    .src_o          (dec_src)
  );

  panel_en_logic u_en (
    .cs_ni     (cs_ni),
    .sclk_i    (sclk_i),
    .axis_i    (axis),
    .pd_i      (pd_i),
    .conv_i    (conv_i),
    .drv_req_o (drv_req),
    .pen_req_o (pen_req)
  );

  panel_sw_seq #(.DEAD_CYCLES(DEAD_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drv_req_i  (drv_req),
    .pen_req_i  (pen_req),
    .pat_i      (pat),
    .touch_i    (touch_i),
    .plate_sw_o (sw),
    .pen_det_o  (pen_det_en_o),
    .pen_irq_no (pen_irq_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    src_q <= SRC_NONE;
    else if (cs_ni) src_q <= SRC_NONE;
    else            src_q <= dec_src;
  end

  assign plate_sw_o = sw;
  assign drv_en_o   = |sw;
  assign adc_src_o  = src_q;

  a_r4_req_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_req && pen_req));
  a_r3_deselect_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (plate_sw_o == '0));
  a_r5_pd11_no_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && pd_i == 2'b11) |=> !pen_det_en_o);
  a_r10_src_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (adc_src_o == SRC_NONE));
endmodule

// File: tb/panel_ctrl_tb_top.sv
module panel_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, se = 1'b1, conv = 1'b0, touch = 1'b0;
  logic [2:0] addr = 3'b000;
  logic [1:0] pd = 2'b00;
  logic drv_en, pen_en, irq_n;
  logic [3:0] sw, src;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  panel_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk),
    .addr_i(addr), .pd_i(pd), .single_ended_i(se), .conv_i(conv),
    .touch_i(touch), .drv_en_o(drv_en), .pen_det_en_o(pen_en),
    .plate_sw_o(sw), .adc_src_o(src), .pen_irq_no(irq_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 10000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {drv, pen, irq_n, sw[3:0], src[3:0]}
  task automatic expect_out(string tag, logic d, logic p, logic i, logic [3:0] s, logic [3:0] c);
    logic [10:0] act, exp;
    act = {drv_en, pen_en, irq_n, sw, src};
    exp = {d, p, i, s, c};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%03h exp=%03h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_out("R1 reset state", 0, 1, 1, 4'b0000, 4'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_pen_idle();
    tick(); expect_out("R4 idle pen path", 0, 1, 1, 4'b0000, 4'd0);
    touch = 1; tick(); expect_out("R6 touch asserts irq", 0, 1, 0, 4'b0000, 4'd0);
    touch = 0; tick(); expect_out("R6 release clears irq", 0, 1, 1, 4'b0000, 4'd0);
    sclk = 1; touch = 1; tick(); expect_out("R4 sclk high drops pen", 0, 0, 1, 4'b0000, 4'd0);
    sclk = 0; touch = 0; tick(); expect_out("R4 sclk low restores pen", 0, 1, 1, 4'b0000, 4'd0);
  endtask

  task automatic t_pd11();
    pd = 2'b11; touch = 1; tick(); expect_out("R5 pd11 disables pen", 0, 0, 1, 4'b0000, 4'd0);
    pd = 2'b10; tick(); expect_out("R4 pd10 pen with touch", 0, 1, 0, 4'b0000, 4'd0);
    pd = 2'b00; touch = 0; tick(); expect_out("R4 pd00 pen", 0, 1, 1, 4'b0000, 4'd0);
  endtask

  task automatic t_axis_drive();
    cs_ni = 0; addr = 3'b101; pd = 2'b01; conv = 0; se = 1;
    tick(); expect_out("R7 pen to X gap", 0, 0, 1, 4'b0000, 4'd2);
    tick(); expect_out("R2 X pattern", 1, 0, 1, 4'b1010, 4'd2);
    addr = 3'b001;
    tick(); expect_out("R7 X to Y gap", 0, 0, 1, 4'b0000, 4'd1);
    tick(); expect_out("R2 Y pattern", 1, 0, 1, 4'b0101, 4'd1);
    addr = 3'b011;
    tick(); expect_out("R7 Y to Z1 gap", 0, 0, 1, 4'b0000, 4'd1);
    tick(); expect_out("R2 Z1 pattern", 1, 0, 1, 4'b0110, 4'd1);
    addr = 3'b100;
    tick(); expect_out("R7 Z1 to Z2 no gap", 1, 0, 1, 4'b0110, 4'd3);
  endtask

  task automatic t_window();
    touch = 1; pd = 2'b00; addr = 3'b101; conv = 0;
    tick(); expect_out("R3 pd0 clear drops drive", 0, 0, 1, 4'b0000, 4'd2);
    tick(); expect_out("R6 pen returns with irq", 0, 1, 0, 4'b0000, 4'd2);
    conv = 1;
    tick(); expect_out("R7 window opens gap", 0, 0, 1, 4'b0000, 4'd2);
    tick(); expect_out("R3 window drives X", 1, 0, 1, 4'b1010, 4'd2);
    conv = 0;
    tick(); expect_out("R7 window closes gap", 0, 0, 1, 4'b0000, 4'd2);
    tick(); expect_out("R6 pen after window", 0, 1, 0, 4'b0000, 4'd2);
    touch = 0;
  endtask

  task automatic t_non_axis();
    addr = 3'b010; pd = 2'b01; conv = 1; se = 1;
    tick(); expect_out("R3 non-axis no drive", 0, 0, 1, 4'b0000, 4'd4);
  endtask

  task automatic t_sources();
    addr = 3'b110; tick(); expect_out("R8 IN1", 0, 0, 1, 4'b0000, 4'd5);
    addr = 3'b000; tick(); expect_out("R8 TEMP0", 0, 0, 1, 4'b0000, 4'd7);
    addr = 3'b111; tick(); expect_out("R8 TEMP1", 0, 0, 1, 4'b0000, 4'd8);
    se = 0;
    addr = 3'b110; tick(); expect_out("R9 IN2", 0, 0, 1, 4'b0000, 4'd6);
    addr = 3'b000; tick(); expect_out("R9 000 none", 0, 0, 1, 4'b0000, 4'd0);
    addr = 3'b111; tick(); expect_out("R9 111 none", 0, 0, 1, 4'b0000, 4'd0);
    addr = 3'b100; tick(); expect_out("R9 diff Z2 from idle", 1, 0, 1, 4'b0110, 4'd3);
  endtask

  task automatic t_deselect();
    cs_ni = 1; sclk = 0; conv = 0; pd = 2'b01;
    tick(); expect_out("R10 deselect gap", 0, 0, 1, 4'b0000, 4'd0);
    tick(); expect_out("R4 deselect pen", 0, 1, 1, 4'b0000, 4'd0);
  endtask

  initial begin
    t_reset();
    t_pen_idle();
    t_pd11();
    t_axis_drive();
    t_window();
    t_non_axis();
    t_sources();
    t_deselect();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule